// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a bus-programmed watchdog that counts down once per clock from a software-chosen start value. The first time the count runs out it raises an interrupt and starts again from the start value. If software has not cleared that interrupt by the time the count runs out a second time, and reset generation is switched on, the block emits a one-cycle system reset request and returns all of its configuration to the power-on state. Software keeps the watchdog quiet by clearing the interrupt, which also restarts the count.

A key register guards the configuration. Writing one particular 32-bit key opens it. Writing any other value closes it. While the configuration is closed, writes to the start value, the control bits and the interrupt clear have no effect, so a runaway program cannot stop the watchdog by accident. The register reads are combinational by default. A parameter selects a registered read path for bus fabrics that need one.

Top module: `wdt2_watchdog`

## Requirements
- R1: After reset the start value and the count both read 0xFFFFFFFF, the control and raw interrupt read 0, the key register reads 0 (open), and `irq_o` and `wd_reset_o` are low.
- R2: Registers sit at byte offsets start value 0x000, count 0x004, control 0x008, interrupt clear 0x00C (write-only, reads 0), raw interrupt 0x010, masked interrupt 0x014 and key 0xC00. Any other offset reads 0.
- R3: Control keeps two bits: bit 0 enables counting and the interrupt output, and bit 1 enables reset generation. Other written bits are dropped and read back as 0. While bit 0 is set, the count drops by one each clock.
- R4: When the count is 0 on an enabled counting clock and no reset follows, the raw interrupt becomes 1 and the count reloads from the start value, so a start value L gives an expiry every L+1 clocks.
- R5: An expiry with control bit 1 set and the raw interrupt already 1 drives `wd_reset_o` high for exactly one clock, starting the clock after the expiry. In that same clock the start value and count read 0xFFFFFFFF again and the control and raw interrupt read 0. With bit 1 clear, the interrupt stays set and the count reloads.
- R6: A start-value write while enabled restarts the count from the written value. While disabled, the write changes only the start value.
- R7: Setting control bit 0 from 0 to 1 reloads the count from the start value. Clearing it freezes the count, which stays readable.
- R8: Any write to the interrupt clear sets the raw interrupt to 0 and, when enabled, reloads the count.
- R9: Writing 0x1ACCE551 to the key register opens the configuration, and any other value closes it. The key register reads 1 when closed. Writes to the start value, the control and the interrupt clear are ignored while closed.
- R10: The masked interrupt read and `irq_o` both equal control bit 0 AND the raw interrupt.
- R11: A clock that carries an accepted write to the start value, control or interrupt clear takes no count step and no expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, which also drives the count |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one clock per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational by default) |
| irq_o | output | 1 | Masked watchdog interrupt |
| wd_reset_o | output | 1 | One-clock system reset request |

## Verification
The bench targets the second expiry. It checks that a pending interrupt together with reset enable produces a pulse exactly one clock long, and that the same pulse also clears the configuration. A design that checks the interrupt after setting it would reset on the first expiry. A design that fails to restore the configuration would pulse again and again. The bench also probes the enable edges: a design that does not reload on the rising edge would start from a stale count, and one that does not freeze on the falling edge would let the count keep moving. Finally, it writes with the configuration closed, writes back-to-back to the control register, and clears the interrupt while disabled. A design that gates on the wrong condition would show a changed start value, a count that drifts, or a count that reloads when it should not.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;

   localparam int OFS_W = 12;

   localparam logic [OFS_W-1:0] OFS_START  = 12'h000;
   localparam logic [OFS_W-1:0] OFS_COUNT  = 12'h004;
   localparam logic [OFS_W-1:0] OFS_CTRL   = 12'h008;
   localparam logic [OFS_W-1:0] OFS_CLEAR  = 12'h00C;
   localparam logic [OFS_W-1:0] OFS_RAW    = 12'h010;
   localparam logic [OFS_W-1:0] OFS_MASKED = 12'h014;
   localparam logic [OFS_W-1:0] OFS_KEY    = 12'hC00;

   localparam int CTRL_W   = 2;
   localparam int CTRL_EN  = 0;
   localparam int CTRL_RST = 1;

   typedef enum logic [2:0] {
      REG_NONE,
      REG_START,
      REG_COUNT,
      REG_CTRL,
      REG_CLEAR,
      REG_RAW,
      REG_MASKED,
      REG_KEY
   } wdt2_reg_e;

   function automatic wdt2_reg_e wdt2_lookup(input logic [OFS_W-1:0] ofs);
      wdt2_reg_e r;
      unique case (ofs)
         OFS_START:  r = REG_START;
         OFS_COUNT:  r = REG_COUNT;
         OFS_CTRL:   r = REG_CTRL;
         OFS_CLEAR:  r = REG_CLEAR;
         OFS_RAW:    r = REG_RAW;
         OFS_MASKED: r = REG_MASKED;
         OFS_KEY:    r = REG_KEY;
         default:    r = REG_NONE;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/wdt2_decode.sv
module wdt2_decode
   import wdt2_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              locked,
   output logic              wr_start,
   output logic              wr_ctrl,
   output logic              wr_clear,
   output logic              wr_key,
   output logic              rd_en,
   output wdt2_reg_e         reg_sel
);

   localparam int HI_W = ADDR_W - OFS_W;

   logic      hi_zero;
   logic      wr_open;

   generate
      if (HI_W > 0) begin : g_hi
         assign hi_zero = (bus_addr[ADDR_W-1:OFS_W] == '0);
      end else begin : g_nohi
         assign hi_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      reg_sel = hi_zero ? wdt2_lookup(bus_addr[OFS_W-1:0]) : REG_NONE;
   end

   assign wr_open  = bus_sel && bus_wr && !locked;
   assign wr_start = wr_open && (reg_sel == REG_START);
   assign wr_ctrl  = wr_open && (reg_sel == REG_CTRL);
   assign wr_clear = wr_open && (reg_sel == REG_CLEAR);
   assign wr_key   = bus_sel && bus_wr && (reg_sel == REG_KEY);
   assign rd_en    = bus_sel && !bus_wr;

endmodule

// File: rtl/wdt2_config.sv
module wdt2_config
   import wdt2_pkg::*;
#(
   parameter int                DATA_W     = 32,
   parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start,
   input  logic              wr_ctrl,
   input  logic              wr_key,
   input  logic [DATA_W-1:0] wdata,
   input  logic              restore,
   output logic [DATA_W-1:0] start_q,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              locked_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '1;
         ctrl_q  <= '0;
      end else if (restore) begin
         start_q <= '1;
         ctrl_q  <= '0;
      end else begin
         if (wr_start) start_q <= wdata;
         if (wr_ctrl)  ctrl_q  <= wdata[CTRL_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      locked_q <= 1'b0;
      else if (wr_key) locked_q <= (wdata != UNLOCK_KEY);
   end

endmodule

// File: rtl/wdt2_core.sv
module wdt2_core
   import wdt2_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] ctrl_q,
   input  logic [DATA_W-1:0] start_q,
   input  logic              wr_start,
   input  logic              wr_ctrl,
   input  logic              wr_clear,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] cnt_q,
   output logic              irq_q,
   output logic              fire_now,
   output logic              fire_q
);

   logic              en;
   logic              step;
   logic              at_zero;
   logic [DATA_W-1:0] cnt_d;
   logic              irq_d;

   assign en      = ctrl_q[CTRL_EN];
   assign step    = en && !(wr_start || wr_ctrl || wr_clear);
   assign at_zero = (cnt_q == '0);
   assign fire_now = step && at_zero && ctrl_q[CTRL_RST] && irq_q;

   always_comb begin
      cnt_d = cnt_q;
      if (fire_now)                           cnt_d = '1;
      else if (wr_start && en)                cnt_d = wdata;
      else if (wr_ctrl && !en && wdata[CTRL_EN]) cnt_d = start_q;
      else if (wr_clear && en)                cnt_d = start_q;
      else if (step)                          cnt_d = at_zero ? start_q : cnt_q - 1'b1;
   end

   always_comb begin
      irq_d = irq_q;
      if (fire_now || wr_clear)  irq_d = 1'b0;
      else if (step && at_zero)  irq_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '1;
         irq_q  <= 1'b0;
         fire_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         irq_q  <= irq_d;
         fire_q <= fire_now;
      end
   end

endmodule

// File: rtl/wdt2_watchdog.sv
module wdt2_watchdog
   import wdt2_pkg::*;
#(
   parameter int                DATA_W     = 32,
   parameter int                ADDR_W     = 12,
   parameter bit                REG_READ   = 1'b0,
   parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o,
   output logic              wd_reset_o
);

   initial begin
      assert (DATA_W >= CTRL_W) else $fatal(1, "DATA_W too narrow for control");
      assert (ADDR_W >= OFS_W)  else $fatal(1, "ADDR_W cannot reach the key offset");
   end

   logic              wr_start, wr_ctrl, wr_clear, wr_key, rd_en;
   wdt2_reg_e         reg_sel;
   logic [DATA_W-1:0] start_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic              locked_q;
   logic [DATA_W-1:0] cnt_q;
   logic              irq_q;
   logic              fire_now;
   logic              fire_q;
   logic              masked;
   logic [DATA_W-1:0] rd_mux;

   wdt2_decode #(.ADDR_W(ADDR_W)) u_decode (
      .bus_sel (bus_sel),
      .bus_wr  (bus_wr),
      .bus_addr(bus_addr),
      .locked  (locked_q),
      .wr_start(wr_start),
      .wr_ctrl (wr_ctrl),
      .wr_clear(wr_clear),
      .wr_key  (wr_key),
      .rd_en   (rd_en),
      .reg_sel (reg_sel)
   );

   wdt2_config #(.DATA_W(DATA_W), .UNLOCK_KEY(UNLOCK_KEY)) u_config (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_start(wr_start),
      .wr_ctrl (wr_ctrl),
      .wr_key  (wr_key),
      .wdata   (bus_wdata),
      .restore (fire_now),
      .start_q (start_q),
      .ctrl_q  (ctrl_q),
      .locked_q(locked_q)
   );

   wdt2_core #(.DATA_W(DATA_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_q  (ctrl_q),
      .start_q (start_q),
      .wr_start(wr_start),
      .wr_ctrl (wr_ctrl),
      .wr_clear(wr_clear),
      .wdata   (bus_wdata),
      .cnt_q   (cnt_q),
      .irq_q   (irq_q),
      .fire_now(fire_now),
      .fire_q  (fire_q)
   );

   assign masked     = ctrl_q[CTRL_EN] & irq_q;
   assign irq_o      = masked;
   assign wd_reset_o = fire_q;

   always_comb begin
      unique case (reg_sel)
         REG_START:  rd_mux = start_q;
         REG_COUNT:  rd_mux = cnt_q;
         REG_CTRL:   rd_mux = DATA_W'(ctrl_q);
         REG_RAW:    rd_mux = DATA_W'(irq_q);
         REG_MASKED: rd_mux = DATA_W'(masked);
         REG_KEY:    rd_mux = DATA_W'(locked_q);
         default:    rd_mux = '0;
      endcase
   end

   generate
      if (REG_READ) begin : g_rd_reg
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rd_q <= '0;
            else if (rd_en) rd_q <= rd_mux;
         end
         assign bus_rdata = rd_q;
      end else begin : g_rd_comb
         assign bus_rdata = rd_en ? rd_mux : '0;
      end
   endgenerate

endmodule

// File: rtl/wdt2_watchdog_chk.sv
module wdt2_watchdog_chk
   import wdt2_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              locked_q,
   input logic [DATA_W-1:0] start_q,
   input logic [CTRL_W-1:0] ctrl_q,
   input logic [DATA_W-1:0] cnt_q,
   input logic              irq_q,
   input logic              irq_o,
   input logic              wd_reset_o
);

   logic any_wr;
   assign any_wr = bus_sel && bus_wr;

   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wd_reset_o |=> !wd_reset_o);

   a_r5_state_restored: assert property (@(posedge clk) disable iff (!rst_n)
      wd_reset_o |-> (ctrl_q == '0 && !irq_q && cnt_q == '1 && start_q == '1));

   a_r5_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_reset_o) |-> $past(irq_q && ctrl_q[CTRL_RST] && ctrl_q[CTRL_EN]));

   a_r4_irq_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[CTRL_EN] && !ctrl_q[CTRL_RST] && cnt_q == '0 && !any_wr) |=> irq_q);

   a_r7_frozen_count: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[CTRL_EN] && !any_wr) |=> $stable(cnt_q));

   a_r9_locked_start: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_q && any_wr && bus_addr == ADDR_W'(OFS_START)
       && !(ctrl_q[CTRL_RST] && irq_q)) |=> $stable(start_q));

   a_r10_irq_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (irq_q && ctrl_q[CTRL_EN]));

endmodule

bind wdt2_watchdog wdt2_watchdog_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .locked_q  (locked_q),
   .start_q   (start_q),
   .ctrl_q    (ctrl_q),
   .cnt_q     (cnt_q),
   .irq_q     (irq_q),
   .irq_o     (irq_o),
   .wd_reset_o(wd_reset_o)
);

// File: tb/wdt2_watchdog_test.sv
module wdt2_watchdog_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;
   logic        wd_reset_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural reference state
   logic [31:0] m_start, m_cnt;
   logic [1:0]  m_ctrl;
   logic        m_irq, m_locked, m_rst;

   always #2 clk = ~clk;

   wdt2_watchdog uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .wd_reset_o(wd_reset_o)
   );

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] model_read(input logic [11:0] a);
      case (a)
         12'h000: return m_start;
         12'h004: return m_cnt;
         12'h008: return {30'd0, m_ctrl};
         12'h010: return {31'd0, m_irq};
         12'h014: return {31'd0, m_irq & m_ctrl[0]};
         12'hC00: return {31'd0, m_locked};
         default: return 32'd0;
      endcase
   endfunction

   task automatic model_reset();
      m_start = '1; m_cnt = '1; m_ctrl = 0; m_irq = 0; m_locked = 0; m_rst = 0;
   endtask

   task automatic model_step(input bit s, input bit w, input logic [11:0] a,
                             input logic [31:0] d);
      bit cfg, pulse;
      cfg = s && w && !m_locked && (a == 12'h000 || a == 12'h008 || a == 12'h00C);
      pulse = 0;
      if (s && w && a == 12'hC00) m_locked = (d != 32'h1ACCE551);
      if (cfg) begin
         if (a == 12'h000) begin
            m_start = d;
            if (m_ctrl[0]) m_cnt = d;
         end else if (a == 12'h008) begin
            if (!m_ctrl[0] && d[0]) m_cnt = m_start;
            m_ctrl = d[1:0];
         end else begin
            m_irq = 0;
            if (m_ctrl[0]) m_cnt = m_start;
         end
      end else if (m_ctrl[0]) begin
         if (m_cnt == 0) begin
            if (m_ctrl[1] && m_irq) begin
               pulse = 1;
               m_start = '1; m_cnt = '1; m_ctrl = 0; m_irq = 0;
            end else begin
               m_irq = 1;
               m_cnt = m_start;
            end
         end else begin
            m_cnt = m_cnt - 1;
         end
      end
      m_rst = pulse;
   endtask

   // one bus clock: drive, compare, advance model
   task automatic cyc(input string tag, input bit s, input bit w,
                      input logic [11:0] a, input logic [31:0] d);
      bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
      #1;
      check(tag, "irq_o", {31'd0, irq_o}, {31'd0, m_irq & m_ctrl[0]});
      check(tag, "wd_reset_o", {31'd0, wd_reset_o}, {31'd0, m_rst});
      if (s && !w) check(tag, $sformatf("read %h", a), bus_rdata, model_read(a));
      @(posedge clk);
      model_step(s, w, a, d);
      @(negedge clk);
   endtask

   task automatic rd(input string tag, input logic [11:0] a);
      cyc(tag, 1, 0, a, 32'd0);
   endtask

   task automatic wr(input string tag, input logic [11:0] a, input logic [31:0] d);
      cyc(tag, 1, 1, a, d);
   endtask

   task automatic idle(input string tag, input int n);
      for (int i = 0; i < n; i++) cyc(tag, 0, 0, 12'h000, 32'd0);
   endtask

   task automatic read_all(input string tag);
      rd(tag, 12'h000); rd(tag, 12'h004); rd(tag, 12'h008);
      rd(tag, 12'h010); rd(tag, 12'h014); rd(tag, 12'hC00);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state, R2 map and unmapped offsets
      read_all("R1");
      rd("R2", 12'h00C); rd("R2", 12'h020); rd("R2", 12'h800);
      // R6 start write while disabled: count untouched
      wr("R6", 12'h000, 32'd5); rd("R6", 12'h004); rd("R6", 12'h000);
      // R3 enable, extra bits dropped; R7 rising edge reloads
      wr("R3", 12'h008, 32'hFFFF_FFFD); rd("R3", 12'h008);
      idle("R3", 2); rd("R3", 12'h004); rd("R3", 12'h004);
      // R4 first expiry sets interrupt and reloads, period L+1
      idle("R4", 3); rd("R4", 12'h010); rd("R4", 12'h004);
      idle("R4", 6); rd("R10", 12'h014);
      // R8 clear while enabled reloads
      wr("R8", 12'h00C, 32'd0); rd("R8", 12'h010); rd("R8", 12'h004);
      idle("R4", 6);
      // R10 disable with pending interrupt: masked 0, raw 1; R7 freeze
      wr("R10", 12'h008, 32'd0); rd("R10", 12'h014); rd("R10", 12'h010);
      rd("R7", 12'h004); idle("R7", 4); rd("R7", 12'h004);
      // R8 clear while disabled: irq drops, count stays
      wr("R8", 12'h00C, 32'd0); rd("R8", 12'h010); rd("R8", 12'h004);
      wr("R7", 12'h008, 32'd1); rd("R7", 12'h004);
      // R6 restart from a new start value while enabled
      wr("R6", 12'h000, 32'd3); rd("R6", 12'h004); idle("R6", 1); rd("R6", 12'h004);
      // R5 without reset enable: second expiry keeps interrupt, no pulse
      idle("R5", 12); read_all("R5");
      // R11 back-to-back control writes hold the count
      for (int i = 0; i < 6; i++) wr("R11", 12'h008, 32'd1);
      rd("R11", 12'h004);
      // R5 with reset enable: pulse, then restored state
      wr("R8", 12'h00C, 32'd0);
      wr("R5", 12'h008, 32'd3);
      idle("R5", 12); read_all("R5"); idle("R5", 4);
      // R9 close with pending interrupt, then try every guarded write
      wr("R9", 12'h000, 32'd2); wr("R9", 12'h008, 32'd1); idle("R9", 4);
      wr("R9", 12'hC00, 32'h1ACC_E550); rd("R9", 12'hC00);
      wr("R9", 12'h000, 32'd9); wr("R9", 12'h008, 32'd0); wr("R9", 12'h00C, 32'd0);
      read_all("R9");
      wr("R9", 12'hC00, 32'h1ACC_E551); rd("R9", 12'hC00);
      wr("R9", 12'h000, 32'd9); wr("R9", 12'h00C, 32'd0); read_all("R9");
      idle("R9", 25); read_all("R9");
      finish_run();
   end

endmodule